// File: doc/BRIEF.md
# GPIO Port Interrupt Detector

This block watches the eight input lines of one GPIO port and decides which of them are asking for service. Each line is given its own sensing mode (level or edge), its own active sense (high/rising or low/falling), its own enable and its own optional input filter. Edge events are caught in a per-line latch that stays set until software acknowledges it. The block drives a status vector with one bit per line and a single port interrupt that is the OR of that vector. Ports are independent: a chip with several ports places one instance per port.

Software configures the block through a simple synchronous write port and reads it back through a combinational read port addressed by the same address bus. The safe way to change a line's mode or sense is to clear its enable bit first and then restore it. A line that must fire on both edges is served by software: it starts the sense opposite to the present pin level and inverts the sense bit at each acknowledge. The block never produces an event from a configuration change alone, so this flip is safe.

Top module: `gpio_irq_port`

## Requirements
- R1: After reset the sense-mode, polarity, enable and filter registers read 0x00, status_o is 0x00 and irq_o is 0.
- R2: Registers decode on addr_i: mode 0x90, polarity 0x94, acknowledge 0x98, enable 0x9C, status 0xA0 (read only), filter enable 0xA8. Written values read back unchanged one cycle after the write; the acknowledge address reads 0x00.
- R3: A line whose mode bit is 0 (level) reports status 1 while it is enabled and its input equals its polarity bit (1 = high, 0 = low), in the same cycle, with no latching.
- R4: A line whose mode bit is 1 (edge) latches a rising input (polarity 1) or falling input (polarity 0) while enabled; its status bit rises at the first clock edge after the input change and holds after the input returns.
- R5: Writing the acknowledge register clears the latched event of every line written as 1; lines written as 0 keep their latch.
- R6: An edge arriving in the same cycle as the acknowledge of that line leaves the latch set.
- R7: A line with enable 0 reports status 0 and its edge latch is cleared; enabling it again does not bring the old event back.
- R8: Writing the polarity, mode or enable bits while the inputs are stable never sets an edge latch.
- R9: With the filter bit set, the filtered level of a line changes only after the raw input has differed from it on 4 consecutive cycles where tick_i is 1; a shorter pulse is discarded, and cycles with tick_i at 0 leave the filter frozen.
- R10: With the filter bit clear, the line's raw input feeds detection directly.
- R11: irq_o is 1 exactly when at least one status_o bit is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous |
| pin_i | input | 8 | Synchronized pin levels |
| tick_i | input | 1 | Filter sample strobe |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 8 | Register address for write and read |
| wdata_i | input | 8 | Register write data |
| rdata_o | output | 8 | Register read data for addr_i |
| status_o | output | 8 | Per-line active interrupt |
| irq_o | output | 1 | Port interrupt, OR of status_o |

## Verification
A stuck or wrongly cleared edge latch shows on status_o and irq_o at the first clock edge after the stimulus that should have set or cleared it, so every edge case is sampled one cycle after it. A filter counter that counts wrong moves the filtered level a cycle early or late, which shows up on status_o in level mode on the exact tick the bench counts to. Wrong register decoding appears at once on rdata_o and, through the mode and polarity bits, on status_o.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int unsigned ADDR_W = 8;

  localparam logic [ADDR_W-1:0] ADR_MODE = 8'h90;
  localparam logic [ADDR_W-1:0] ADR_POL  = 8'h94;
  localparam logic [ADDR_W-1:0] ADR_ACK  = 8'h98;
  localparam logic [ADDR_W-1:0] ADR_ENA  = 8'h9C;
  localparam logic [ADDR_W-1:0] ADR_STAT = 8'hA0;
  localparam logic [ADDR_W-1:0] ADR_FILT = 8'hA8;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_MODE, SEL_POL, SEL_ACK, SEL_ENA, SEL_STAT, SEL_FILT
  } reg_sel_e;

  function automatic reg_sel_e decode(input logic [ADDR_W-1:0] a);
    case (a)
      ADR_MODE: return SEL_MODE;
      ADR_POL:  return SEL_POL;
      ADR_ACK:  return SEL_ACK;
      ADR_ENA:  return SEL_ENA;
      ADR_STAT: return SEL_STAT;
      ADR_FILT: return SEL_FILT;
      default:  return SEL_NONE;
    endcase
  endfunction
endpackage

// File: rtl/gpio_irq_regs.sv
module gpio_irq_regs
  import gpio_irq_pkg::*;
#(
  parameter int unsigned N_LINES = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [N_LINES-1:0] wdata_i,
  output logic [N_LINES-1:0] mode_o,
  output logic [N_LINES-1:0] pol_o,
  output logic [N_LINES-1:0] ena_o,
  output logic [N_LINES-1:0] filt_o,
  output logic [N_LINES-1:0] ack_o
);
  reg_sel_e wsel;
  assign wsel  = decode(addr_i);
  assign ack_o = (wr_en_i && wsel == SEL_ACK) ? wdata_i : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_o <= '0;
      pol_o  <= '0;
      ena_o  <= '0;
      filt_o <= '0;
    end else if (wr_en_i) begin
      case (wsel)
        SEL_MODE: mode_o <= wdata_i;
        SEL_POL:  pol_o  <= wdata_i;
        SEL_ENA:  ena_o  <= wdata_i;
        SEL_FILT: filt_o <= wdata_i;
        default:  ;
      endcase
    end
  end

  // R2
  ena_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && addr_i == ADR_ENA) |=> (ena_o == $past(wdata_i)));
endmodule

// File: rtl/gpio_irq_filter.sv
module gpio_irq_filter #(
  parameter int unsigned N_LINES  = 8,
  parameter int unsigned DB_COUNT = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick_i,
  input  logic [N_LINES-1:0] raw_i,
  input  logic [N_LINES-1:0] filt_en_i,
  output logic [N_LINES-1:0] eff_o
);
  localparam int unsigned CW = (DB_COUNT < 2) ? 1 : $clog2(DB_COUNT);
  localparam logic [CW-1:0] LAST = CW'(DB_COUNT - 1);

  logic [N_LINES-1:0] held;

  for (genvar g = 0; g < N_LINES; g++) begin : g_line
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        held[g] <= 1'b0;
        cnt     <= '0;
      end else if (!filt_en_i[g]) begin
        held[g] <= raw_i[g];
        cnt     <= '0;
      end else if (tick_i) begin
        if (raw_i[g] == held[g]) begin
          cnt <= '0;
        end else if (cnt == LAST) begin
          held[g] <= raw_i[g];
          cnt     <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end

    assign eff_o[g] = filt_en_i[g] ? held[g] : raw_i[g];

    // R9
    filter_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(filt_en_i[g]) && held[g] != $past(held[g]))
        |-> ($past(tick_i) && $past(cnt) == LAST));
  end
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect #(
  parameter int unsigned N_LINES = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_LINES-1:0] eff_i,
  input  logic [N_LINES-1:0] mode_i,
  input  logic [N_LINES-1:0] pol_i,
  input  logic [N_LINES-1:0] ena_i,
  input  logic [N_LINES-1:0] ack_i,
  output logic [N_LINES-1:0] status_o
);
  function automatic logic [N_LINES-1:0] level_match(
    input logic [N_LINES-1:0] lvl, input logic [N_LINES-1:0] pol);
    return ~(lvl ^ pol);
  endfunction

  function automatic logic [N_LINES-1:0] edge_match(
    input logic [N_LINES-1:0] prev, input logic [N_LINES-1:0] now,
    input logic [N_LINES-1:0] pol);
    return (pol & ~prev & now) | (~pol & prev & ~now);
  endfunction

  logic [N_LINES-1:0] prev_q;
  logic [N_LINES-1:0] latch_q;
  logic [N_LINES-1:0] edge_set;
  logic [N_LINES-1:0] latch_clr;

  assign edge_set  = ena_i & mode_i & edge_match(prev_q, eff_i, pol_i);
  assign latch_clr = ack_i | ~ena_i | ~mode_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q  <= '0;
      latch_q <= '0;
    end else begin
      prev_q  <= eff_i;
      latch_q <= edge_set | (latch_q & ~latch_clr);
    end
  end

  assign status_o = ena_i & ((mode_i & latch_q) | (~mode_i & level_match(eff_i, pol_i)));

  // R4
  edge_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(edge_set) & ~latch_q) == '0);

  // R5
  latch_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(latch_q) & ~latch_q & ~$past(latch_clr)) == '0);
endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port
  import gpio_irq_pkg::*;
#(
  parameter int unsigned N_LINES  = 8,
  parameter int unsigned DB_COUNT = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_LINES-1:0] pin_i,
  input  logic               tick_i,
  input  logic               wr_en_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [N_LINES-1:0] wdata_i,
  output logic [N_LINES-1:0] rdata_o,
  output logic [N_LINES-1:0] status_o,
  output logic               irq_o
);
  logic [N_LINES-1:0] mode, pol, ena, filt, ack, eff;

  gpio_irq_regs #(.N_LINES(N_LINES)) regs_i (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .mode_o(mode), .pol_o(pol), .ena_o(ena),
    .filt_o(filt), .ack_o(ack)
  );

  gpio_irq_filter #(.N_LINES(N_LINES), .DB_COUNT(DB_COUNT)) filt_i (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .raw_i(pin_i),
    .filt_en_i(filt), .eff_o(eff)
  );

  gpio_irq_detect #(.N_LINES(N_LINES)) det_i (
    .clk(clk), .rst_n(rst_n), .eff_i(eff), .mode_i(mode), .pol_i(pol),
    .ena_i(ena), .ack_i(ack), .status_o(status_o)
  );

  assign irq_o = |status_o;

  always_comb begin
    case (decode(addr_i))
      SEL_MODE: rdata_o = mode;
      SEL_POL:  rdata_o = pol;
      SEL_ENA:  rdata_o = ena;
      SEL_FILT: rdata_o = filt;
      SEL_STAT: rdata_o = status_o;
      default:  rdata_o = '0;
    endcase
  end

  // R7
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status_o & ~ena) == '0);
endmodule

// File: tb/gpio_irq_port_tb.sv
module gpio_irq_port_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] pin_i = '0;
  logic       tick_i = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [7:0] addr_i = '0;
  logic [7:0] wdata_i = '0;
  logic [7:0] rdata_o, status_o;
  logic       irq_o;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  gpio_irq_port dut_i (
    .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .tick_i(tick_i),
    .wr_en_i(wr_en_i), .addr_i(addr_i), .wdata_i(wdata_i),
    .rdata_o(rdata_o), .status_o(status_o), .irq_o(irq_o)
  );

  // {polarity, enable, pins} for level-mode walk
  localparam logic [23:0] LVL_VEC [6] = '{
    24'hFF_FF_00, 24'h00_FF_00, 24'hF0_FF_3C,
    24'hAA_0F_55, 24'h0F_F0_FF, 24'h81_FF_81
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    wr_en_i = 1'b1; addr_i = a; wdata_i = d;
    step(1);
    wr_en_i = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    addr_i = a;
    #1 d = rdata_o;
  endtask

  initial begin
    logic [7:0] v, exp;
    step(3);
    rst_n = 1'b1;
    step(1);
    // R1 reset state
    chk("R1 status", status_o, 8'h00);
    chk("R1 irq", {7'b0, irq_o}, 8'h00);
    rd(8'h90, v); chk("R1 mode", v, 8'h00);
    rd(8'h94, v); chk("R1 pol", v, 8'h00);
    rd(8'h9C, v); chk("R1 ena", v, 8'h00);
    rd(8'hA8, v); chk("R1 filt", v, 8'h00);

    // R2 map and readback
    wr(8'h90, 8'h12); wr(8'h94, 8'h34); wr(8'hA8, 8'h56);
    rd(8'h90, v); chk("R2 mode", v, 8'h12);
    rd(8'h94, v); chk("R2 pol", v, 8'h34);
    rd(8'hA8, v); chk("R2 filt", v, 8'h56);
    rd(8'h98, v); chk("R2 ack reads 0", v, 8'h00);
    wr(8'h90, 8'h00); wr(8'hA8, 8'h00);

    // R3 R10 R11 level-mode table
    foreach (LVL_VEC[i]) begin
      wr(8'h94, LVL_VEC[i][23:16]);
      wr(8'h9C, LVL_VEC[i][15:8]);
      pin_i = LVL_VEC[i][7:0];
      #1;
      exp = LVL_VEC[i][15:8] & ~(LVL_VEC[i][7:0] ^ LVL_VEC[i][23:16]);
      chk("R3 level status", status_o, exp);
      chk("R11 irq", {7'b0, irq_o}, {7'b0, |exp});
      step(1);
    end
    rd(8'hA0, v); chk("R2 status read", v, exp);

    // R4 edge mode: lines 0-3 rising, 4-7 falling
    wr(8'h9C, 8'h00);
    pin_i = 8'hF0;
    wr(8'h90, 8'hFF); wr(8'h94, 8'h0F); wr(8'h9C, 8'hFF);
    step(1);
    chk("R8 enable no event", status_o, 8'h00);
    pin_i = 8'hF5;
    #1 chk("R4 not before edge", status_o, 8'h00);
    step(1);
    chk("R4 rising latched", status_o, 8'h05);
    pin_i = 8'h50;
    step(1);
    chk("R4 falling latched, held", status_o, 8'hA5);
    chk("R11 irq edge", {7'b0, irq_o}, 8'h01);

    // R5 acknowledge
    wr(8'h98, 8'h01);
    chk("R5 ack one line", status_o, 8'hA4);
    wr(8'h98, 8'h00);
    chk("R5 zero bits keep", status_o, 8'hA4);

    // R8 polarity and mode rewrite
    wr(8'h94, 8'hFF);
    wr(8'h94, 8'h0F);
    chk("R8 polarity flip", status_o, 8'hA4);

    // R6 edge meets acknowledge
    pin_i = 8'h51;
    wr(8'h98, 8'h01);
    chk("R6 edge wins", status_o, 8'hA5);

    // R7 disable clears
    wr(8'h9C, 8'h00);
    chk("R7 disabled", status_o, 8'h00);
    chk("R7 irq off", {7'b0, irq_o}, 8'h00);
    wr(8'h9C, 8'hFF);
    chk("R7 no revive", status_o, 8'h00);

    // R9 filter
    wr(8'h9C, 8'h00);
    pin_i = 8'h00;
    wr(8'h90, 8'h00); wr(8'h94, 8'hFF); wr(8'hA8, 8'h01); wr(8'h9C, 8'h01);
    tick_i = 1'b1;
    step(2);
    chk("R9 start low", status_o, 8'h00);
    pin_i = 8'h01;
    step(3);
    chk("R9 3 ticks no change", status_o, 8'h00);
    step(1);
    chk("R9 4th tick changes", status_o, 8'h01);
    pin_i = 8'h00;
    step(2);
    pin_i = 8'h01;
    step(3);
    chk("R9 glitch rejected", status_o, 8'h01);
    tick_i = 1'b0;
    pin_i = 8'h00;
    step(6);
    chk("R9 frozen without tick", status_o, 8'h01);
    tick_i = 1'b1;
    step(3);
    chk("R9 3 ticks hold", status_o, 8'h01);
    step(1);
    chk("R9 falls on 4th", status_o, 8'h00);
    tick_i = 1'b0;

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #4000000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule